// File: doc/BRIEF.md
# User-Bit Triple Block Relay

This block carries the user (U) bit channel of a digital audio stream from a receive side to a transmit side one whole block at a time. A block is 384 U bits (192 frames of two subframes each). The bits pass through three block-sized stores in cascade: a fill store that collects the block being received, a middle store, and a drain store that the transmitter shifts out bit by bit. At every receive block start the contents move one place along the cascade. A received block therefore reaches the transmitter after two boundaries.

A host sees only the middle store, through a byte-wide read/write port. Between boundaries it can decode the block that has just been received and overwrite any byte of it. Its changes then travel on to the drain store at the next boundary. This is the only way for host-supplied U data to reach the transmitted stream. The host view is one stream of bytes with no split by channel. Byte 0 holds the earliest bits of the block. Within each byte the most significant bit is the earliest bit, both for received and for transmitted data.

Both sides run on one clock with separate enables. The block does not interpret the U data.

Top module: `ublk_relay`

## Requirements
- R1: After reset, tx_bit, host_rdata and host_busy are 0, and every byte of the middle store reads 0.
- R2: A receive strobe (rx_bit_en) with rx_blk_start stores its bit as bit 0 of a new block. Later strobes store bits 1, 2 and so on up to bit 383. Strobes before the first block start are discarded, and so are strobes after bit 383.
- R3: On a receive strobe with rx_blk_start, the middle store takes the previous fill-store block and the drain store takes the previous middle-store block. The fill store restarts cleared, so positions that a short block never wrote read as 0.
- R4: Host byte n holds block bit 8n in data bit 7 and block bit 8n+7 in data bit 0.
- R5: An accepted host read (host_sel=1, host_wr=0, host_busy=0) of address a shows its byte on host_rdata after the next clock edge. Addresses 48 and above read as 0. host_rdata keeps its value when no read is accepted.
- R6: An accepted host write (host_sel=1, host_wr=1, host_busy=0) replaces middle-store byte a, and the change moves to the drain store at the next boundary. Writes to addresses 48 and above have no effect.
- R7: host_busy is 1 exactly in a cycle that carries a receive block start. A host access in that cycle is not performed: a write is lost and host_rdata is unchanged.
- R8: On a transmit request (tx_bit_req) with tx_blk_start, tx_bit shows drain-store bit 0 after the next edge. Later requests show bits 1, 2 and so on. Requests before the first transmit block start, or after bit 383, give 0. tx_bit holds its value while no request is made.
- R9: With no host writes, a block received in full comes out of the transmitter unchanged after two receive boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit_en | input | 1 | Receive U-bit strobe |
| rx_bit | input | 1 | Received U bit |
| rx_blk_start | input | 1 | The strobed bit is bit 0 of a block |
| tx_bit_req | input | 1 | Transmit U-bit request |
| tx_blk_start | input | 1 | The request is for bit 0 of a block |
| tx_bit | output | 1 | Transmitted U bit, registered |
| host_sel | input | 1 | Host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Byte address in the middle store |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| host_busy | output | 1 | Access stalled this cycle by a boundary |

## Verification
The assertions assume that a host which sees host_busy will repeat its access, and that requests are presented only after reset has been released. The receive and transmit enables may arrive in any pattern, including both in the same cycle. The stimulus drives every input half a cycle away from the active edge. It mixes random block contents and random host bytes from a fixed seed with directed cases: blocks longer and shorter than 384 bits, out-of-range addresses, host accesses that land on a boundary, and transmit requests past the end of the block.

// File: rtl/ublk_pkg.sv
package ublk_pkg;

  // Host byte view: the earliest block bit sits in data bit 7.
  function automatic logic [7:0] lane_swap(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

endpackage

// File: rtl/ublk_rx_fill.sv
module ublk_rx_fill #(
  parameter int BITS = 384,
  parameter int IW   = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            bit_in,
  input  logic            blk_start,
  output logic [BITS-1:0] fill_q,
  output logic [IW-1:0]   idx_q,
  output logic            adv
);
  logic room;

  assign adv  = bit_en & blk_start;
  assign room = idx_q < IW'(BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      idx_q  <= IW'(BITS);          // idle until first block start
    end else if (adv) begin
      fill_q <= {{(BITS-1){1'b0}}, bit_in};
      idx_q  <= IW'(1);
    end else if (bit_en && room) begin
      fill_q[idx_q] <= bit_in;
      idx_q         <= idx_q + IW'(1);
    end
  end
endmodule

// File: rtl/ublk_mid_store.sv
module ublk_mid_store
  import ublk_pkg::*;
#(
  parameter int BITS  = 384,
  parameter int BYTES = BITS / 8,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [BITS-1:0] fill_q,
  input  logic            host_sel,
  input  logic            host_wr,
  input  logic [AW-1:0]   host_addr,
  input  logic [7:0]      host_wdata,
  output logic [BITS-1:0] mid_q,
  output logic [7:0]      host_rdata,
  output logic            wr_fire,
  output logic            rd_fire
);
  logic       in_range;
  logic       acc_ok;
  logic [7:0] rd_view [BYTES];

  assign in_range = {1'b0, host_addr} < (AW+1)'(BYTES);
  assign acc_ok   = host_sel & ~adv;
  assign wr_fire  = acc_ok & host_wr & in_range;
  assign rd_fire  = acc_ok & ~host_wr;

  for (genvar n = 0; n < BYTES; n++) begin : g_view
    assign rd_view[n] = lane_swap(mid_q[8*n +: 8]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_q <= '0;
    end else if (adv) begin
      mid_q <= fill_q;
    end else if (wr_fire) begin
      for (int n = 0; n < BYTES; n++)
        if (host_addr == AW'(n)) mid_q[8*n +: 8] <= lane_swap(host_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (rd_fire) host_rdata <= in_range ? rd_view[host_addr] : 8'h00;
  end
endmodule

// File: rtl/ublk_tx_drain.sv
module ublk_tx_drain #(
  parameter int BITS = 384,
  parameter int IW   = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [BITS-1:0] mid_q,
  input  logic            bit_req,
  input  logic            blk_start,
  output logic            tx_bit,
  output logic            past_end
);
  logic [BITS-1:0] out_q;
  logic [IW-1:0]   idx_q;

  assign past_end = idx_q >= IW'(BITS);

  always_ff @(posedge clk) begin
    if (!rst_n)   out_q <= '0;
    else if (adv) out_q <= mid_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= IW'(BITS);
      tx_bit <= 1'b0;
    end else if (bit_req) begin
      if (blk_start) begin
        tx_bit <= out_q[0];
        idx_q  <= IW'(1);
      end else if (!past_end) begin
        tx_bit <= out_q[idx_q];
        idx_q  <= idx_q + IW'(1);
      end else begin
        tx_bit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ublk_relay.sv
module ublk_relay #(
  parameter int FRAMES    = 192,
  parameter int SUBFRAMES = 2,
  localparam int BITS     = FRAMES * SUBFRAMES,
  localparam int BYTES    = BITS / 8,
  localparam int AW       = $clog2(BYTES),
  localparam int IW       = $clog2(BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_bit_en,
  input  logic          rx_bit,
  input  logic          rx_blk_start,
  input  logic          tx_bit_req,
  input  logic          tx_blk_start,
  output logic          tx_bit,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          host_busy
);
  // Named internal events, used by the bound checker.
  logic            blk_adv;
  logic            host_wr_fire;
  logic            host_rd_fire;
  logic            tx_past_end;
  logic [IW-1:0]   rx_idx;
  logic [BITS-1:0] fill_q;
  logic [BITS-1:0] mid_q;

  ublk_rx_fill #(.BITS(BITS), .IW(IW)) u_fill (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .bit_in(rx_bit),
    .blk_start(rx_blk_start), .fill_q(fill_q), .idx_q(rx_idx), .adv(blk_adv)
  );

  ublk_mid_store #(.BITS(BITS), .BYTES(BYTES), .AW(AW)) u_mid (
    .clk(clk), .rst_n(rst_n), .adv(blk_adv), .fill_q(fill_q),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .mid_q(mid_q), .host_rdata(host_rdata),
    .wr_fire(host_wr_fire), .rd_fire(host_rd_fire)
  );

  ublk_tx_drain #(.BITS(BITS), .IW(IW)) u_drain (
    .clk(clk), .rst_n(rst_n), .adv(blk_adv), .mid_q(mid_q),
    .bit_req(tx_bit_req), .blk_start(tx_blk_start),
    .tx_bit(tx_bit), .past_end(tx_past_end)
  );

  assign host_busy = blk_adv;
endmodule

// File: rtl/ublk_relay_chk.sv
module ublk_relay_chk #(
  parameter int BYTES = 48,
  parameter int AW    = 6,
  parameter int IW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_bit_req,
  input logic          tx_blk_start,
  input logic          tx_bit,
  input logic          tx_past_end,
  input logic          host_sel,
  input logic          host_wr,
  input logic [AW-1:0] host_addr,
  input logic [7:0]    host_rdata,
  input logic          host_busy,
  input logic          host_wr_fire,
  input logic          host_rd_fire,
  input logic          blk_adv,
  input logic [IW-1:0] rx_idx
);
  // R8: output holds with no request
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit_req |=> $stable(tx_bit));

  // R8: past the end of the block the output is zero
  assert_tx_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_req && !tx_blk_start && tx_past_end) |=> !tx_bit);

  // R7: read stalled by busy leaves read data untouched
  assert_busy_read_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && host_busy) |=> $stable(host_rdata));

  // R7: write stalled by busy never fires
  assert_busy_write_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr && host_busy) |-> !host_wr_fire);

  // R5: out-of-range reads return zero
  assert_rd_range_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_fire && ({1'b0, host_addr} >= (AW+1)'(BYTES))) |=> (host_rdata == 8'h00));

  // R3: a boundary restarts the fill position after bit 0
  assert_fill_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_adv |=> (rx_idx == IW'(1)));
endmodule

bind ublk_relay ublk_relay_chk #(.BYTES(BYTES), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_bit_req(tx_bit_req), .tx_blk_start(tx_blk_start),
  .tx_bit(tx_bit), .tx_past_end(tx_past_end), .host_sel(host_sel),
  .host_wr(host_wr), .host_addr(host_addr), .host_rdata(host_rdata),
  .host_busy(host_busy), .host_wr_fire(host_wr_fire),
  .host_rd_fire(host_rd_fire), .blk_adv(blk_adv), .rx_idx(rx_idx)
);

// File: tb/ublk_relay_tb.sv
module ublk_relay_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BITS  = 384;
  localparam int BYTES = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_bit_en = 0, rx_bit = 0, rx_blk_start = 0;
  logic tx_bit_req = 0, tx_blk_start = 0, tx_bit;
  logic host_sel = 0, host_wr = 0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic host_busy;

  int n_tests = 0, n_fail = 0, cycles = 0;
  logic [BITS-1:0] m1 = '0, m2 = '0, m3 = '0;
  logic [BITS-1:0] blk_a, blk_b;
  int ridx = BITS, tidx = BITS;
  logic [7:0] exp_rd = 8'h00;
  logic exp_txq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ublk_relay u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit_en(rx_bit_en), .rx_bit(rx_bit),
    .rx_blk_start(rx_blk_start), .tx_bit_req(tx_bit_req),
    .tx_blk_start(tx_blk_start), .tx_bit(tx_bit), .host_sel(host_sel),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_busy(host_busy)
  );

  function automatic logic [7:0] pack(input logic [BITS-1:0] m, input int n);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[7-j] = m[8*n+j];
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic re, rb, rs, tq, ts, hs, hw,
                     input int ha, input logic [7:0] hd, input string tag);
    logic bnd;
    logic [BITS-1:0] o2, o3;
    logic e;
    @(negedge clk);
    rx_bit_en = re; rx_bit = rb; rx_blk_start = rs;
    tx_bit_req = tq; tx_blk_start = ts;
    host_sel = hs; host_wr = hw; host_addr = 6'(ha); host_wdata = hd;
    #1;
    bnd = re & rs;
    if (hs) check({tag, " busy R7"}, host_busy, bnd);
    @(posedge clk); #1;
    o2 = m2; o3 = m3;
    if (tq) begin
      if (ts) begin e = o3[0]; tidx = 1; end
      else if (tidx < BITS) begin e = o3[tidx]; tidx++; end
      else e = 1'b0;
      exp_txq = e;
      check({tag, " tx"}, tx_bit, e);
    end
    if (hs && !bnd) begin
      if (!hw) exp_rd = (ha < BYTES) ? pack(o2, ha) : 8'h00;
      else if (ha < BYTES)
        for (int j = 0; j < 8; j++) m2[8*ha+j] = hd[7-j];
    end
    if (hs && !hw) check({tag, " rdata"}, host_rdata, exp_rd);
    if (re) begin
      if (rs) begin
        m3 = m2; m2 = m1; m1 = '0; m1[0] = rb; ridx = 1;
      end else if (ridx < BITS) begin
        m1[ridx] = rb; ridx++;
      end
    end
    rx_bit_en = 0; rx_blk_start = 0; tx_bit_req = 0; tx_blk_start = 0;
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rxb(input logic b, input logic s);
    cyc(1, b, s, 0, 0, 0, 0, 0, 8'h00, "rx");
  endtask
  task automatic txr(input logic s, input string tag);
    cyc(0, 0, 0, 1, s, 0, 0, 0, 8'h00, tag);
  endtask
  task automatic hrd(input int a, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 0, a, 8'h00, tag);
  endtask
  task automatic hwr(input int a, input logic [7:0] d);
    cyc(0, 0, 0, 0, 0, 1, 1, a, d, "wr");
  endtask
  task automatic send_block(input logic [BITS-1:0] v, input int nbits);
    for (int k = 0; k < nbits; k++) rxb(v[k], k == 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 tx_bit", tx_bit, 0);
    check("R1 rdata", host_rdata, 0);
    check("R1 busy", host_busy, 0);
    for (int n = 0; n < BYTES; n++) hrd(n, "R1 mid zero");
    for (int k = 0; k < 3; k++) txr(0, "R8 tx before start");

    // R2: bits before the first start are dropped
    for (int k = 0; k < 10; k++) rxb(1'b1, 1'b0);
    for (int k = 0; k < BITS; k++) blk_a[k] = 1'($urandom);
    for (int k = 0; k < BITS; k++) blk_b[k] = 1'($urandom);
    send_block(blk_a, BITS);
    for (int k = 0; k < 20; k++) rxb(1'b1, 1'b0);   // R2 overflow dropped
    send_block(blk_b, 1);                           // R3 boundary
    for (int n = 0; n < BYTES; n++) begin
      hrd(n, "R2 R4 mid=A");
      check("R4 packing direct", host_rdata, pack(blk_a, n));
    end

    // R5 R6: host writes, in and out of range
    for (int k = 0; k < 6; k++) begin
      int a;
      a = int'($urandom % BYTES);
      hwr(a, 8'($urandom));
      hrd(a, "R6 write readback");
    end
    hwr(0, 8'h81);
    hwr(BYTES - 1, 8'h3C);
    hwr(50, 8'hFF);
    hrd(50, "R5 range zero");
    for (int n = 0; n < BYTES; n++) hrd(n, "R6 mid after writes");

    for (int k = 1; k < BITS; k++) rxb(blk_b[k], 1'b0);
    // R7: write lands on boundary, lost; starts short block C
    cyc(1, 1'b1, 1, 0, 0, 1, 1, 3, 8'h5A, "R7 write on boundary");
    hrd(3, "R7 write lost");
    check("R7 lost vs B", host_rdata, pack(blk_b, 3));
    for (int k = 1; k < 100; k++) rxb(1'($urandom), 1'b0);

    // R6 R8: drain store holds A with host edits
    txr(1, "R6 R8 tx start");
    for (int k = 1; k < BITS; k++) begin
      txr(0, "R6 R8 tx stream");
      if (k % 97 == 0) begin
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "idle");
        check("R8 hold", tx_bit, exp_txq);
      end
    end
    for (int k = 0; k < 5; k++) txr(0, "R8 past end");

    // R7 R3: read on boundary is stalled, then C short block reads
    cyc(1, 1'b0, 1, 0, 0, 1, 0, 20, 8'h00, "R7 read on boundary");
    for (int n = 0; n < BYTES; n++) hrd(n, "R3 short block");
    hrd(20, "R3 short tail zero");
    check("R3 tail zero direct", host_rdata, 0);

    // R9: B unchanged two boundaries later
    txr(1, "R9 tx");
    check("R9 bit0 direct", tx_bit, blk_b[0]);
    for (int k = 1; k < BITS; k++) begin
      txr(0, "R9 tx");
      check("R9 direct", tx_bit, blk_b[k]);
    end
    // R8: restart mid-stream
    for (int k = 0; k < 7; k++) txr(k == 0, "R8 first pass");
    txr(1, "R8 restart");
    check("R8 restart direct", tx_bit, blk_b[0]);
    txr(0, "R8 restart bit1");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule